// File: doc/BRIEF.md
# PS/2 to Polled-Host Keyboard Bridge

This block sits between a PS/2 keyboard byte receiver and a host that reads the keyboard by polling. Its input is the stream of scan-code bytes from the PS/2 side, one byte per strobe. A prefix state machine collapses the variable-length make and break sequences into single key events. A lookup table gives each supported key a 6-bit host key number, and keys with no host equivalent are discarded. A bitmap of keys that are held down filters out the make codes the keyboard repeats on its own. The events that survive are packed into one-byte transition codes and queued in a small FIFO.

The host writes a command byte and waits for the response flag, then reads the byte and acknowledges it. An inquiry returns the oldest queued code. If the queue is empty, the block waits for a key up to a programmable number of clock cycles and then answers with a null code. An instant command answers at once, with no wait. A model query and a self-test command each return a fixed byte.

Top module: `kbb_bridge`

## Requirements
- R1: After synchronous reset, `resp_ready` is 0, the key queue is empty and no key is held, so an instant command (0x14) returns the null code 0x7B.
- R2: Each queued code is one byte: bit 0 is always 1, bits 6..1 are the host key number, and bit 7 is 1 for a release and 0 for a press. Plain codes map 0x1C→0x00, 0x1B→0x01, 0x23→0x02, 0x2B→0x03, 0x15→0x0C, 0x1D→0x0D, 0x24→0x0E, 0x2D→0x0F, 0x29→0x31, 0x5A→0x24, 0x66→0x33, 0x0D→0x30, 0x76→0x35, 0x12→0x38, 0x14→0x36.
- R3: A byte 0xE0 marks the next code as extended, and a byte 0xF0 marks it as a release. Both may precede one code, in the order E0 F0 code. Extended codes map 0x6B→0x3B, 0x74→0x3C, 0x72→0x3D, 0x75→0x3E, 0x11→0x3A.
- R4: Any plain or extended code not listed in R2/R3 produces nothing, with or without a release prefix.
- R5: A press of a key already held is dropped, and a release of a key not held is dropped. A press is queued only on the key's first make, and a release only on its break.
- R6: The queue holds FIFO_DEPTH (8) codes and returns them oldest first. An event that arrives while the queue is full is dropped and leaves the held-key bitmap unchanged.
- R7: An inquiry (0x10) with queued data raises `resp_ready` after the clock edge that takes the command and presents the oldest code, which leaves the queue.
- R8: An inquiry with an empty queue waits. If a key is queued during the wait, that code is returned. Otherwise 0x7B is returned, with `resp_ready` rising exactly WAIT_CYCLES clock edges after the edge that took the command.
- R9: An instant command (0x14) answers after the command edge with the oldest code, or with 0x7B when the queue is empty.
- R10: A model query (0x16) answers 0x0B and a self-test (0x36) answers 0x7D, after the command edge.
- R11: `resp_ready` and `resp_byte` hold until `host_rd`. Commands written while a response is pending or an inquiry is waiting are ignored, and so are command bytes not listed above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ps2_valid | input | 1 | One-cycle strobe: `ps2_byte` holds a received byte |
| ps2_byte | input | 8 | Byte from the PS/2 receiver |
| host_wr | input | 1 | One-cycle strobe: `host_cmd` holds a command |
| host_cmd | input | 8 | Host command byte |
| host_rd | input | 1 | Host acknowledges the pending response |
| resp_byte | output | 8 | Response byte |
| resp_ready | output | 1 | A response is pending |

## Verification
The bench runs every byte value through the decoder, both plain and after the extended prefix. Each code is sent as a make, a repeated make and a break, and the queue is drained after each one. A wrong table entry or a prefix that is not cleared would show up as a stray or missing code. A broken repeat filter would queue a second press, or would queue a release with no press before it. Overfilling the queue tests two things: that the ninth and tenth presses are lost, and that their later releases are suppressed because the bitmap was not updated. A misplaced counter compare would move the null reply of the timed inquiry by one cycle. A key that arrives during the wait must end the wait early with that key's code. Commands sent while a response is pending must not replace it.

// File: rtl/kbb_pkg.sv
package kbb_pkg;

    localparam int KEY_W = 6;
    localparam int KEYS  = 1 << KEY_W;

    localparam logic [7:0] CMD_INQUIRY  = 8'h10;
    localparam logic [7:0] CMD_INSTANT  = 8'h14;
    localparam logic [7:0] CMD_MODEL    = 8'h16;
    localparam logic [7:0] CMD_SELFTEST = 8'h36;

    localparam logic [7:0] REPLY_NULL   = 8'h7B;
    localparam logic [7:0] REPLY_MODEL  = 8'h0B;
    localparam logic [7:0] REPLY_PASS   = 8'h7D;

    localparam logic [7:0] PFX_EXT      = 8'hE0;
    localparam logic [7:0] PFX_BRK      = 8'hF0;

    typedef struct packed {
        logic             brk;
        logic [KEY_W-1:0] key;
    } key_ev_t;

    typedef struct packed {
        logic             hit;
        logic [KEY_W-1:0] key;
    } map_res_t;

    function automatic map_res_t map_code(input logic ext, input logic [7:0] code);
        map_res_t r;
        r.hit = 1'b1;
        r.key = '0;
        if (!ext) begin
            case (code)
                8'h1C: r.key = 6'h00;
                8'h1B: r.key = 6'h01;
                8'h23: r.key = 6'h02;
                8'h2B: r.key = 6'h03;
                8'h15: r.key = 6'h0C;
                8'h1D: r.key = 6'h0D;
                8'h24: r.key = 6'h0E;
                8'h2D: r.key = 6'h0F;
                8'h29: r.key = 6'h31;
                8'h5A: r.key = 6'h24;
                8'h66: r.key = 6'h33;
                8'h0D: r.key = 6'h30;
                8'h76: r.key = 6'h35;
                8'h12: r.key = 6'h38;
                8'h14: r.key = 6'h36;
                default: r.hit = 1'b0;
            endcase
        end else begin
            case (code)
                8'h6B: r.key = 6'h3B;
                8'h74: r.key = 6'h3C;
                8'h72: r.key = 6'h3D;
                8'h75: r.key = 6'h3E;
                8'h11: r.key = 6'h3A;
                default: r.hit = 1'b0;
            endcase
        end
        return r;
    endfunction

    function automatic logic [7:0] pack_event(input key_ev_t e);
        return {e.brk, e.key, 1'b1};
    endfunction

endpackage

// File: rtl/kbb_rx_decode.sv
module kbb_rx_decode
    import kbb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output logic       ev_valid,
    output key_ev_t    ev
);
    logic     ext_q;
    logic     brk_q;
    logic     is_prefix;
    map_res_t lk;

    assign is_prefix = (in_byte == PFX_EXT) || (in_byte == PFX_BRK);
    assign lk        = map_code(ext_q, in_byte);
    assign ev_valid  = in_valid && !is_prefix && lk.hit;
    assign ev.brk    = brk_q;
    assign ev.key    = lk.key;

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_q <= 1'b0;
            brk_q <= 1'b0;
        end else if (in_valid) begin
            if (in_byte == PFX_EXT) begin
                ext_q <= 1'b1;
            end else if (in_byte == PFX_BRK) begin
                brk_q <= 1'b1;
            end else begin
                ext_q <= 1'b0;
                brk_q <= 1'b0;
            end
        end
    end

    assert_prefix_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !is_prefix) |=> (!ext_q && !brk_q));

endmodule

// File: rtl/kbb_key_filter.sv
module kbb_key_filter
    import kbb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ev_valid,
    input  key_ev_t    ev,
    input  logic       q_full,
    output logic       push,
    output logic [7:0] push_byte
);
    logic [KEYS-1:0] held;

    assign push      = ev_valid && (ev.brk == held[ev.key]) && !q_full;
    assign push_byte = pack_event(ev);

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (push) begin
            held[ev.key] <= !ev.brk;
        end
    end

    assert_bitmap_tracks_R5: assert property (@(posedge clk) disable iff (rst)
        push |=> (held[$past(ev.key)] == !$past(ev.brk)));

    assert_full_keeps_bitmap_R6: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && q_full) |=> $stable(held));

endmodule

// File: rtl/kbb_fifo.sv
module kbb_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [CW-1:0]    count;
    logic             do_push;
    logic             do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign dout    = mem[rd_ptr];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    assert_no_empty_pop_R7: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/kbb_bridge.sv
module kbb_bridge
    import kbb_pkg::*;
#(
    parameter int WAIT_CYCLES = 16000000,
    parameter int FIFO_DEPTH  = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ps2_valid,
    input  logic [7:0] ps2_byte,
    input  logic       host_wr,
    input  logic [7:0] host_cmd,
    input  logic       host_rd,
    output logic [7:0] resp_byte,
    output logic       resp_ready
);
    localparam int TW = $clog2(WAIT_CYCLES + 1);

    typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_HOLD} host_st_t;

    host_st_t   st;
    logic [TW-1:0] wait_cnt;

    logic       ev_valid;
    key_ev_t    ev;
    logic       q_push;
    logic [7:0] q_din;
    logic       q_pop;
    logic [7:0] q_head;
    logic       q_empty;
    logic       q_full;
    logic       take_key;

    kbb_rx_decode u_dec (
        .clk      (clk),
        .rst      (rst),
        .in_valid (ps2_valid),
        .in_byte  (ps2_byte),
        .ev_valid (ev_valid),
        .ev       (ev)
    );

    kbb_key_filter u_filt (
        .clk       (clk),
        .rst       (rst),
        .ev_valid  (ev_valid),
        .ev        (ev),
        .q_full    (q_full),
        .push      (q_push),
        .push_byte (q_din)
    );

    kbb_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_q (
        .clk   (clk),
        .rst   (rst),
        .push  (q_push),
        .din   (q_din),
        .pop   (q_pop),
        .dout  (q_head),
        .empty (q_empty),
        .full  (q_full)
    );

    assign take_key = (st == ST_IDLE) && host_wr &&
                      ((host_cmd == CMD_INQUIRY) || (host_cmd == CMD_INSTANT));
    assign q_pop      = !q_empty && (take_key || (st == ST_WAIT));
    assign resp_ready = (st == ST_HOLD);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            wait_cnt  <= '0;
            resp_byte <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (host_wr) begin
                        case (host_cmd)
                            CMD_INQUIRY: begin
                                if (!q_empty) begin
                                    resp_byte <= q_head;
                                    st        <= ST_HOLD;
                                end else begin
                                    wait_cnt <= '0;
                                    st       <= ST_WAIT;
                                end
                            end
                            CMD_INSTANT: begin
                                resp_byte <= q_empty ? REPLY_NULL : q_head;
                                st        <= ST_HOLD;
                            end
                            CMD_MODEL: begin
                                resp_byte <= REPLY_MODEL;
                                st        <= ST_HOLD;
                            end
                            CMD_SELFTEST: begin
                                resp_byte <= REPLY_PASS;
                                st        <= ST_HOLD;
                            end
                            default: st <= ST_IDLE;
                        endcase
                    end
                end
                ST_WAIT: begin
                    if (!q_empty) begin
                        resp_byte <= q_head;
                        st        <= ST_HOLD;
                    end else if (wait_cnt == TW'(WAIT_CYCLES - 1)) begin
                        resp_byte <= REPLY_NULL;
                        st        <= ST_HOLD;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (host_rd) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assert_hold_until_read_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(resp_ready) |-> $past(host_rd));

    assert_byte_stable_R11: assert property (@(posedge clk) disable iff (rst)
        (resp_ready && $past(resp_ready)) |-> $stable(resp_byte));

    assert_odd_reply_R2: assert property (@(posedge clk) disable iff (rst)
        resp_ready |-> resp_byte[0]);

    assert_wait_bound_R8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT) |-> (wait_cnt < TW'(WAIT_CYCLES)));

endmodule

// File: tb/kbb_bridge_tb.sv
module kbb_bridge_tb_top;

    localparam int W = 40;

    logic       clk = 1'b0;
    logic       rst;
    logic       ps2_valid;
    logic [7:0] ps2_byte;
    logic       host_wr;
    logic [7:0] host_cmd;
    logic       host_rd;
    logic [7:0] resp_byte;
    logic       resp_ready;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 0;

    logic [7:0] mq [0:7];
    int  mcount = 0;
    bit  mheld [0:63];

    always #2 clk = ~clk;

    kbb_bridge #(.WAIT_CYCLES(W), .FIFO_DEPTH(8)) dut_i (
        .clk(clk), .rst(rst), .ps2_valid(ps2_valid), .ps2_byte(ps2_byte),
        .host_wr(host_wr), .host_cmd(host_cmd), .host_rd(host_rd),
        .resp_byte(resp_byte), .resp_ready(resp_ready)
    );

    function automatic int kmap(input bit ext, input logic [7:0] c);
        if (!ext) begin
            case (c)
                8'h1C: return 'h00; 8'h1B: return 'h01; 8'h23: return 'h02;
                8'h2B: return 'h03; 8'h15: return 'h0C; 8'h1D: return 'h0D;
                8'h24: return 'h0E; 8'h2D: return 'h0F; 8'h29: return 'h31;
                8'h5A: return 'h24; 8'h66: return 'h33; 8'h0D: return 'h30;
                8'h76: return 'h35; 8'h12: return 'h38; 8'h14: return 'h36;
                default: return -1;
            endcase
        end
        case (c)
            8'h6B: return 'h3B; 8'h74: return 'h3C; 8'h72: return 'h3D;
            8'h75: return 'h3E; 8'h11: return 'h3A;
            default: return -1;
        endcase
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_ev(input bit brk, input int key);
        if (key < 0) return;
        if ((brk == mheld[key]) && (mcount < 8)) begin
            mq[mcount] = {brk, key[5:0], 1'b1};
            mcount++;
            mheld[key] = !brk;
        end
    endtask

    function automatic logic [7:0] model_pop();
        logic [7:0] v;
        if (mcount == 0) return 8'h7B;
        v = mq[0];
        for (int i = 1; i < 8; i++) mq[i-1] = mq[i];
        mcount--;
        return v;
    endfunction

    task automatic ps2(input logic [7:0] b);
        @(negedge clk); ps2_valid = 1'b1; ps2_byte = b;
        @(negedge clk); ps2_valid = 1'b0;
    endtask

    task automatic key(input bit ext, input bit brk, input logic [7:0] c);
        if (ext) ps2(8'hE0);
        if (brk) ps2(8'hF0);
        ps2(c);
        model_ev(brk, kmap(ext, c));
    endtask

    task automatic cmd(input logic [7:0] c);
        @(negedge clk); host_wr = 1'b1; host_cmd = c;
        @(negedge clk); host_wr = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk); host_rd = 1'b1;
        @(negedge clk); host_rd = 1'b0;
    endtask

    task automatic drain(input string req);
        logic [7:0] e;
        for (int i = 0; i < 12; i++) begin
            cmd(8'h14);
            e = model_pop();
            chk(req, {7'b0, resp_ready}, 8'h01);
            chk(req, resp_byte, e);
            ack();
            if (e == 8'h7B) break;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] fill [0:9];
        logic [7:0] e;
        fill = '{8'h1C, 8'h1B, 8'h23, 8'h2B, 8'h15, 8'h1D, 8'h24, 8'h2D, 8'h29, 8'h5A};
        for (int i = 0; i < 64; i++) mheld[i] = 1'b0;
        rst = 1'b1; ps2_valid = 1'b0; ps2_byte = '0;
        host_wr = 1'b0; host_cmd = '0; host_rd = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1 ready", {7'b0, resp_ready}, 8'h00);
        drain("R1 empty");

        // R2 R3 R4 R5: sweep of every code, plain and extended
        for (int x = 0; x < 2; x++) begin
            for (int c = 0; c < 256; c++) begin
                if (c == 'hE0 || c == 'hF0) continue;
                key(x[0], 1'b0, c[7:0]);
                key(x[0], 1'b0, c[7:0]);
                key(x[0], 1'b1, c[7:0]);
                key(x[0], 1'b1, c[7:0]);
                if (kmap(x[0], c[7:0]) < 0) drain("R4 unmapped");
                else drain("R2 R3 R5 mapped");
            end
        end

        // R6: overfill the queue, then release everything
        for (int i = 0; i < 10; i++) key(1'b0, 1'b0, fill[i]);
        drain("R6 full drop");
        for (int i = 0; i < 10; i++) key(1'b0, 1'b1, fill[i]);
        drain("R6 bitmap unchanged");
        key(1'b0, 1'b0, fill[8]); key(1'b0, 1'b0, fill[9]);
        key(1'b0, 1'b1, fill[8]); key(1'b0, 1'b1, fill[9]);
        drain("R6 late keys");

        // R7: inquiry with data answers at once
        key(1'b0, 1'b0, 8'h1C);
        key(1'b0, 1'b1, 8'h1C);
        cmd(8'h10);
        chk("R7 ready", {7'b0, resp_ready}, 8'h01);
        chk("R7 byte", resp_byte, model_pop());
        ack();
        cmd(8'h10);
        chk("R7 second", resp_byte, model_pop());
        ack();

        // R8: timed inquiry with null reply
        cmd(8'h10);
        for (int k = 1; k <= W; k++) begin
            @(negedge clk);
            if (k < W) chk("R8 waiting", {7'b0, resp_ready}, 8'h00);
            else begin
                chk("R8 timeout ready", {7'b0, resp_ready}, 8'h01);
                chk("R8 null", resp_byte, 8'h7B);
            end
        end
        ack();

        // R8: key arriving during the wait
        cmd(8'h10);
        repeat (5) @(negedge clk);
        key(1'b1, 1'b0, 8'h74);
        @(negedge clk);
        chk("R8 arrival ready", {7'b0, resp_ready}, 8'h01);
        chk("R8 arrival byte", resp_byte, model_pop());
        ack();
        key(1'b1, 1'b1, 8'h74);

        // R9: instant with data, then empty
        cmd(8'h14);
        chk("R9 data", resp_byte, model_pop());
        ack();
        cmd(8'h14);
        chk("R9 null", resp_byte, 8'h7B);
        ack();

        // R10: model and self-test
        cmd(8'h16);
        chk("R10 model", resp_byte, 8'h0B);
        ack();
        cmd(8'h36);
        chk("R10 selftest", resp_byte, 8'h7D);
        ack();

        // R11: pending response holds; later and unknown commands ignored
        cmd(8'h16);
        cmd(8'h36);
        repeat (3) @(negedge clk);
        chk("R11 held ready", {7'b0, resp_ready}, 8'h01);
        chk("R11 held byte", resp_byte, 8'h0B);
        ack();
        repeat (3) @(negedge clk);
        chk("R11 no second", {7'b0, resp_ready}, 8'h00);
        cmd(8'h55);
        repeat (5) @(negedge clk);
        chk("R11 unknown", {7'b0, resp_ready}, 8'h00);
        e = 8'h00;
        drain("R11 queue intact");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule